// File: doc/BRIEF.md
# Tag Session Command Processor

This block runs the card side of a simulated contactless memory-card session. It sits between a bit-level receiver and transmitter. The receiver delivers a decoded frame, its bit count, and valid and error strobes. The block answers by requesting transmit frames and by reading and writing its own byte memory.

A session opens with a three-step handshake. The reader sends a 7-bit start frame. The block replies with a 6-bit frame naming its card type. The reader then sends a 6-bit confirmation. Once the session is linked, the block tells read and write commands apart only by their bit count. Every reply byte carries a 4-bit CRC, and a write takes effect only after its CRC has been checked. The CRC is computed serially, one bit per clock.

A static parameter picks one of three card sizes, and that choice sets the command and address widths. When the handshake completes, the block emits a single-cycle strobe that tells the timing logic to move its reference point forward by one bit period.

Top module: `tag_session`

## Requirements
- R1: After reset, `linked` is 0 and none of the strobes `tx_req`, `tx_ack`, `ts_bump`, `mem_re` or `mem_we` is high.
- R2: While idle, a valid frame of length 7 makes the block request one reply with `tx_len`=6 and `tx_data[5:0]` equal to the card-type code (0x0D, 0x1D or 0x3D for type 0, 1 or 2). A valid frame of any other length while idle produces no reply.
- R3: After the type reply, a valid 6-bit frame whose value is the confirmation code (0x19 for type 0, 0x39 for types 1 and 2) sets `linked` and pulses `ts_bump` for one cycle. Any other frame in that step drops back to idle with no pulse.
- R4: `rx_error` returns the block to idle from any step (`linked`=0).
- R5: While linked, a valid frame whose length equals the command width CW (6, 9 or 11 for type 0, 1 or 2) is a read of address `frame[CW-1:1]`. The reply has `tx_len`=12, the stored byte in bits 7:0 and the CRC in bits 11:8.
- R6: The CRC is 4 bits wide. It starts at 0x5, has no final inversion, and is computed LSB first over the (8+CW)-bit value (byte << CW) | command. For each bit b, with f = crc[0]^b, the register shifts right by one and is XORed with 0xC when f is 1.
- R7: While linked, a valid frame of length CW+12 is a write. The address is `frame[CW-1:1]`, the data byte is `frame[CW+7:CW]` and the CRC is `frame[CW+11:CW+8]`. The CRC is recomputed over (byte << CW) | (address << 1). On a match, the block pulses `mem_we` with that address and byte, pulses `tx_ack`, and stays linked.
- R8: On a write CRC mismatch, the memory is left unchanged, no acknowledge is sent, and the session returns to idle.
- R9: While linked, a valid frame whose length is neither CW nor CW+12 returns the session to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a received frame is ready |
| rx_error | input | 1 | One-cycle strobe: the receiver saw a fault |
| rx_frame | input | 23 | Received frame, first bit in bit 0 |
| rx_len | input | 5 | Bit count of the received frame |
| tx_req | output | 1 | One-cycle request to send `tx_data` |
| tx_ack | output | 1 | One-cycle request to send the write acknowledge |
| tx_data | output | 12 | Frame to transmit |
| tx_len | output | 4 | Bit count of `tx_data` |
| ts_bump | output | 1 | Advance the timing reference by one bit period |
| linked | output | 1 | Session is past the handshake |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 10 | Address of the current access |
| mem_wdata | output | 8 | Byte being written |

## Verification
Writes with random addresses, data and ignored bit 0 are paired with later reads. These pairs separate correct address slicing and CRC bit ordering from plausible mistakes: an MSB-first CRC, a wrong initial value, or a shifted address. Directed frames exercise the lowest and highest addresses. The handshake is also driven with the wrong confirmation code, with a wrong start length, and with an error in the middle of it. Corrupted write CRCs and off-length frames show whether the session truly drops. A later read of the same address then shows that a bad write left the byte untouched.

// File: rtl/tag_session.sv
module tag_session #(
  parameter int CARD_TYPE = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic        rx_error,
  input  logic [22:0] rx_frame,
  input  logic [4:0]  rx_len,
  output logic        tx_req,
  output logic        tx_ack,
  output logic [11:0] tx_data,
  output logic [3:0]  tx_len,
  output logic        ts_bump,
  output logic        linked,
  output logic        mem_re,
  output logic        mem_we,
  output logic [9:0]  mem_addr,
  output logic [7:0]  mem_wdata
);
  localparam int CW     = (CARD_TYPE == 0) ? 6 : (CARD_TYPE == 1) ? 9 : 11;
  localparam int AW     = CW - 1;
  localparam int DEPTH  = 1 << AW;
  localparam int NBITS  = 8 + CW;
  localparam logic [5:0] TYPE_CODE = (CARD_TYPE == 0) ? 6'h0D : (CARD_TYPE == 1) ? 6'h1D : 6'h3D;
  localparam logic [5:0] CONF_CODE = (CARD_TYPE == 0) ? 6'h19 : 6'h39;
  localparam logic [3:0] CRC_SEED  = 4'h5;
  localparam logic [3:0] CRC_POLY  = 4'hC;

  typedef enum logic [2:0] {S_IDLE, S_CONF, S_LINK, S_FETCH, S_CRC} st_t;
  st_t st;

  logic [7:0]     ram [DEPTH];
  logic [7:0]     rdata;
  logic [AW-1:0]  rd_addr;
  logic [CW-1:0]  cmd_q;
  logic [AW-1:0]  addr_q;
  logic [7:0]     byte_q;
  logic [3:0]     crc_exp, crc;
  logic [18:0]    sh;
  logic [4:0]     cnt;
  logic           is_wr;
  logic           crc_ok, wr_fire;
  logic           fb;

  assign rd_addr = rx_frame[CW-1:1];
  assign linked  = (st == S_LINK) || (st == S_FETCH) || (st == S_CRC);
  assign crc_ok  = (crc == crc_exp);
  assign wr_fire = (st == S_CRC) && (cnt == 0) && is_wr && crc_ok && !rx_error;
  assign fb      = crc[0] ^ sh[0];

  always_ff @(posedge clk) begin
    if (wr_fire) ram[addr_q] <= byte_q;
    rdata <= ram[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tx_req    <= 1'b0;
      tx_ack    <= 1'b0;
      tx_data   <= '0;
      tx_len    <= '0;
      ts_bump   <= 1'b0;
      mem_re    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      cmd_q     <= '0;
      addr_q    <= '0;
      byte_q    <= '0;
      crc_exp   <= '0;
      crc       <= CRC_SEED;
      sh        <= '0;
      cnt       <= '0;
      is_wr     <= 1'b0;
    end else begin
      tx_req  <= 1'b0;
      tx_ack  <= 1'b0;
      ts_bump <= 1'b0;
      mem_re  <= 1'b0;
      mem_we  <= 1'b0;
      if (rx_error) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: if (rx_valid && rx_len == 5'd7) begin
            tx_req  <= 1'b1;
            tx_data <= {6'd0, TYPE_CODE};
            tx_len  <= 4'd6;
            st      <= S_CONF;
          end
          S_CONF: if (rx_valid) begin
            if (rx_len == 5'd6 && rx_frame[5:0] == CONF_CODE) begin
              ts_bump <= 1'b1;
              st      <= S_LINK;
            end else begin
              st <= S_IDLE;
            end
          end
          S_LINK: if (rx_valid) begin
            if (rx_len == 5'(CW)) begin
              cmd_q    <= rx_frame[CW-1:0];
              mem_re   <= 1'b1;
              mem_addr <= 10'(rd_addr);
              is_wr    <= 1'b0;
              st       <= S_FETCH;
            end else if (rx_len == 5'(CW + 12)) begin
              addr_q  <= rx_frame[CW-1:1];
              byte_q  <= rx_frame[CW+7:CW];
              crc_exp <= rx_frame[CW+11:CW+8];
              sh      <= 19'({rx_frame[CW+7:CW], rx_frame[CW-1:1], 1'b0});
              crc     <= CRC_SEED;
              cnt     <= 5'(NBITS);
              is_wr   <= 1'b1;
              st      <= S_CRC;
            end else begin
              st <= S_IDLE;
            end
          end
          S_FETCH: begin
            byte_q <= rdata;
            sh     <= 19'({rdata, cmd_q});
            crc    <= CRC_SEED;
            cnt    <= 5'(NBITS);
            st     <= S_CRC;
          end
          S_CRC: begin
            if (cnt != 0) begin
              crc <= (crc >> 1) ^ (fb ? CRC_POLY : 4'h0);
              sh  <= sh >> 1;
              cnt <= cnt - 5'd1;
            end else if (is_wr) begin
              if (crc_ok) begin
                mem_we    <= 1'b1;
                mem_addr  <= 10'(addr_q);
                mem_wdata <= byte_q;
                tx_ack    <= 1'b1;
                st        <= S_LINK;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              tx_req  <= 1'b1;
              tx_data <= {crc, byte_q};
              tx_len  <= 4'd12;
              st      <= S_LINK;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R1
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_req, tx_ack, ts_bump, mem_re}));
  // R2
  setup_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && !linked) |-> (tx_len == 4'd6));
  // R5
  read_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && linked) |-> (tx_len == 4'd12));
  // R3
  bump_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ts_bump |=> !ts_bump);
  // R7
  write_linked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (linked && tx_ack));
  // R4
  error_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_error |=> !linked);
endmodule

// File: tb/tag_session_tb.sv
module tag_session_tb;
  localparam int CW = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic        rx_error = 1'b0;
  logic [22:0] rx_frame = '0;
  logic [4:0]  rx_len = '0;
  logic        tx_req, tx_ack, ts_bump, linked, mem_re, mem_we;
  logic [11:0] tx_data;
  logic [3:0]  tx_len;
  logic [9:0]  mem_addr;
  logic [7:0]  mem_wdata;

  always #2.5 clk = ~clk;

  tag_session #(.CARD_TYPE(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_error(rx_error),
    .rx_frame(rx_frame), .rx_len(rx_len), .tx_req(tx_req), .tx_ack(tx_ack),
    .tx_data(tx_data), .tx_len(tx_len), .ts_bump(ts_bump), .linked(linked),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  int n_pass = 0;
  int n_total = 0;
  bit finished = 0;

  logic [7:0] model [1024];
  bit         known [1024];

  bit         g_req, g_ack, g_bump, g_we;
  logic [11:0] g_data;
  logic [3:0]  g_len;
  logic [9:0]  g_waddr;
  logic [7:0]  g_wdata;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (ok) n_pass++;
    else $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
  endtask

  function automatic logic [3:0] crc4(input logic [18:0] d, input int n);
    logic [3:0] c = 4'h5;
    for (int i = 0; i < n; i++) begin
      logic f = c[0] ^ d[i];
      c = (c >> 1) ^ (f ? 4'hC : 4'h0);
    end
    return c;
  endfunction

  task automatic xfer(input logic [22:0] f, input logic [4:0] n);
    @(negedge clk);
    rx_valid = 1'b1; rx_frame = f; rx_len = n;
    @(negedge clk);
    rx_valid = 1'b0;
    g_req = 0; g_ack = 0; g_bump = 0; g_we = 0;
    for (int i = 0; i < 40; i++) begin
      if (tx_req && !g_req) begin g_req = 1; g_data = tx_data; g_len = tx_len; end
      if (tx_ack) g_ack = 1;
      if (ts_bump) g_bump = 1;
      if (mem_we && !g_we) begin g_we = 1; g_waddr = mem_addr; g_wdata = mem_wdata; end
      @(negedge clk);
    end
  endtask

  task automatic err_pulse();
    @(negedge clk); rx_error = 1'b1;
    @(negedge clk); rx_error = 1'b0;
  endtask

  task automatic open_session();
    xfer(23'($urandom & 32'h7F), 5'd7);
    check(g_req && g_len == 4'd6 && g_data[5:0] == 6'h3D, "R2 type reply", {20'd0, g_data}, 32'h3D);
    xfer(23'h39, 5'd6);
    check(g_bump && linked, "R3 confirm links", {30'd0, g_bump, linked}, 32'h3);
  endtask

  task automatic do_write(input logic [9:0] a, input logic [7:0] b, input bit bad);
    logic [3:0] c = crc4({b, a, 1'b0}, 8 + CW);
    logic [3:0] cs = bad ? (c ^ 4'(1 + ($urandom % 15))) : c;
    xfer({cs, b, a, 1'($urandom)}, 5'(CW + 12));
    if (!bad) begin
      check(g_ack && g_we && g_waddr == a && g_wdata == b && linked, "R7 write accepted",
            {g_ack, g_we, linked, 9'd0, g_waddr, g_wdata}, {3'b111, 9'd0, a, b});
      model[a] = b; known[a] = 1;
    end else begin
      check(!g_ack && !g_we && !linked, "R8 bad crc rejected", {29'd0, g_ack, g_we, linked}, 32'd0);
    end
  endtask

  task automatic do_read(input logic [9:0] a);
    logic b0 = 1'($urandom);
    logic [10:0] cmd = {a, b0};
    logic [11:0] exp = {crc4({model[a], cmd}, 8 + CW), model[a]};
    xfer(23'(cmd), 5'(CW));
    check(g_req && g_len == 4'd12 && g_data == exp && linked, "R5 R6 read reply",
          {g_req, 15'd0, g_len, g_data}, {1'b1, 15'd0, 4'd12, exp});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_pass, n_total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 1024; i++) known[i] = 0;
    repeat (3) @(negedge clk);
    check(!linked && !tx_req && !tx_ack && !ts_bump && !mem_re && !mem_we, "R1 reset state",
          {26'd0, linked, tx_req, tx_ack, ts_bump, mem_re, mem_we}, 32'd0);
    rst_n = 1'b1;

    xfer(23'h15, 5'd6);
    check(!g_req && !linked, "R2 wrong start length", {30'd0, g_req, linked}, 32'd0);

    xfer(23'h2A, 5'd7);
    check(g_req && g_len == 4'd6 && g_data[5:0] == 6'h3D, "R2 type reply", {20'd0, g_data}, 32'h3D);
    xfer(23'h19, 5'd6);
    check(!g_bump && !linked, "R3 wrong confirm", {30'd0, g_bump, linked}, 32'd0);

    xfer(23'h11, 5'd7);
    err_pulse();
    xfer(23'h39, 5'd6);
    check(!g_bump && !linked, "R4 error during setup", {30'd0, g_bump, linked}, 32'd0);

    open_session();
    err_pulse();
    @(negedge clk);
    check(!linked, "R4 error while linked", {31'd0, linked}, 32'd0);

    open_session();
    do_write(10'd0, 8'hA5, 0);
    do_write(10'd1023, 8'h3C, 0);
    do_read(10'd0);
    do_read(10'd1023);
    for (int k = 0; k < 40; k++) begin
      logic [9:0] a = 10'($urandom);
      do_write(a, 8'($urandom), 0);
    end
    for (int k = 0; k < 40; k++) begin
      logic [9:0] a = 10'($urandom);
      while (!known[a]) a = a + 10'd1;
      do_read(a);
    end

    do_write(10'd0, 8'h5A, 1);
    open_session();
    do_read(10'd0);
    check(model[0] == 8'hA5, "R8 memory kept", {24'd0, model[0]}, 32'hA5);

    for (int k = 0; k < 5; k++) begin
      logic [9:0] a = 10'($urandom);
      do_write(a, 8'($urandom), 1);
      open_session();
      if (known[a]) do_read(a);
    end

    xfer(23'h1234, 5'd15);
    check(!g_req && !g_ack && !linked, "R9 odd length drops", {29'd0, g_req, g_ack, linked}, 32'd0);
    xfer(23'h0, 5'(CW));
    check(!g_req, "R9 read ignored after drop", {31'd0, g_req}, 32'd0);

    finished = 1;
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end
endmodule